// File: doc/BRIEF.md
# Modulo Loop Control Unit

This block sequences a software-pipelined loop whose kernel is a single copy of code. It keeps a trip counter, a drain counter and a rotating file of one-bit stage enables. Each loop-closing operation does three things. It decides whether the kernel branch is taken, it steps the rotation pointer, and it writes a fresh enable bit into the slot that becomes stage 0. A stage enable vector therefore grows from one bit during the prologue, stays full through the steady state and empties during the epilogue, with no separate prologue or epilogue code.

Two loop styles are served. Counted loops use the trip counter and then the drain counter. Condition-driven loops take the new enable from a loop condition ANDed with an incoming predicate and drain with the drain counter only. Each style has a "stay in loop" form and a "quit" form with the opposite branch sense. A plain rotate operation is also provided. Software presets the counters and the enable file through load ports before the loop starts. For an S-stage counted loop of T iterations it loads trip=T-1, drain=S-1 and enables=1 in stage 0 only.

Top module: `modulo_loop_ctl`

## Requirements
- R1: While reset is asserted, and at the first idle cycle after it, `brTaken` is 0 and `stageEn` is all zeros. The trip counter and drain counter reset to 0.
- R2: Op code 3'd1 (counted loop-back) with trip counter > 0 decrements the trip counter and rotates. Rotating shifts `stageEn` up by one position (bit i moves to bit i+1) and writes 1 into bit 0. The branch is taken. For a 5-stage loop loaded with trip 6 and drain 4, stage 4 is enabled on exactly 7 passes.
- R3: Op code 3'd1 with trip counter = 0 and drain counter > 0 decrements the drain counter, rotates with 0 written into bit 0, and takes the branch. The 5-stage, 7-iteration case gives 10 taken branches followed by 1 not-taken branch.
- R4: Op code 3'd1 with both counters at 0 is not taken and changes no state. Neither counter ever goes below zero.
- R5: Op code 3'd2 (counted quit) updates state exactly like 3'd1. Its branch is taken only when the trip counter was 0 at issue.
- R6: Op code 3'd3 (conditional loop-back) ignores the trip counter and forms the new enable as `loopCond & inPred`. If that enable is 1, it rotates it in and the branch is taken. Otherwise, if the drain counter is > 0, it decrements the drain counter, rotates in 0 and the branch is taken. Otherwise the branch is not taken and no state changes.
- R7: Op code 3'd4 (conditional quit) updates state like 3'd3. Its branch is taken exactly when `loopCond & inPred` is 0.
- R8: Op code 3'd5 rotates with 1 written into bit 0 regardless of the counters. It never asserts `brTaken`.
- R9: In a cycle with any of `lcLoadEn`, `escLoadEn` or `predInitEn` high, the loads take effect and a strobed operation is discarded: `brTaken` is 0 and no rotation happens.
- R10: Op codes 3'd0, 3'd6 and 3'd7 have no effect on state or outputs.
- R11: `brTaken` and the new `stageEn` appear in the cycle after the operation strobe. `brTaken` is 0 in any cycle that follows a cycle without a valid operation.
- R12: `predInitEn` sets stage predicate i to `predInitVal[i]` relative to the current rotation pointer, whatever rotations came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operation strobe |
| opCode | input | 3 | Operation code (see R2 to R10) |
| loopCond | input | 1 | Loop condition for the conditional forms |
| inPred | input | 1 | Incoming predicate for the conditional forms |
| lcLoadEn | input | 1 | Load the trip counter |
| lcLoadVal | input | CNT_W | Trip counter load value |
| escLoadEn | input | 1 | Load the drain counter |
| escLoadVal | input | CNT_W | Drain counter load value |
| predInitEn | input | 1 | Initialize the stage predicates |
| predInitVal | input | PRED_N | Predicate values, bit i for stage i |
| brTaken | output | 1 | Registered branch decision |
| stageEn | output | PRED_N | Stage enable vector, bit i enables stage i |

## Verification
Every result of this block is due one clock after the edge that samples the strobe or load. This covers the branch decision, the shifted enable vector and the counter effects that later decisions reveal. The bench drives each stimulus on a falling edge and updates its behavioural model at once. It then compares `brTaken` and `stageEn` at the next falling edge, which is one rising edge later. The counters are never read directly. Their values show up in which later operation is taken and which bit is shifted in, so every step of every scenario is compared, including idle steps.

// File: rtl/modulo_loop_pkg.sv
package modulo_loop_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_CTOP   = 3'd1,
    OP_CQUIT  = 3'd2,
    OP_WTOP   = 3'd3,
    OP_WQUIT  = 3'd4,
    OP_ROTATE = 3'd5
  } loop_op_e;

  typedef struct packed {
    logic rotate;
    logic newBit;
    logic decLc;
    logic decEsc;
  } loop_strobe_t;

endpackage

// File: rtl/modulo_loop_ctrl.sv
module modulo_loop_ctrl
  import modulo_loop_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         opValid,
  input  logic [2:0]   opCode,
  input  logic         loopCond,
  input  logic         inPred,
  input  logic         anyLoad,
  input  logic         lcZero,
  input  logic         escZero,
  output loop_strobe_t strobe,
  output logic         brTaken
);

  logic takeNow;
  logic condBit;
  logic keepGoing;

  assign condBit = loopCond & inPred;

  always_comb begin
    strobe    = '0;
    takeNow   = 1'b0;
    keepGoing = 1'b0;
    if (opValid && !anyLoad) begin
      case (opCode)
        OP_CTOP, OP_CQUIT: begin
          if (!lcZero) begin
            strobe.rotate = 1'b1;
            strobe.newBit = 1'b1;
            strobe.decLc  = 1'b1;
            keepGoing     = 1'b1;
          end else if (!escZero) begin
            strobe.rotate = 1'b1;
            strobe.decEsc = 1'b1;
            keepGoing     = 1'b1;
          end
          takeNow = (opCode == OP_CTOP) ? keepGoing : lcZero;
        end
        OP_WTOP, OP_WQUIT: begin
          if (condBit) begin
            strobe.rotate = 1'b1;
            strobe.newBit = 1'b1;
            keepGoing     = 1'b1;
          end else if (!escZero) begin
            strobe.rotate = 1'b1;
            strobe.decEsc = 1'b1;
            keepGoing     = 1'b1;
          end
          takeNow = (opCode == OP_WTOP) ? keepGoing : !condBit;
        end
        OP_ROTATE: begin
          strobe.rotate = 1'b1;
          strobe.newBit = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) brTaken <= 1'b0;
    else       brTaken <= takeNow;
  end

  // R11: no strobe, no branch in the following cycle
  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !brTaken);

  // R9: a load in the same cycle suppresses the operation
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && anyLoad) |=> !brTaken);

  // R8: rotate never branches
  assert_rotate_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !anyLoad && opCode == OP_ROTATE) |=> !brTaken);

endmodule

// File: rtl/modulo_loop_counters.sv
module modulo_loop_counters
  import modulo_loop_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lcLoadEn,
  input  logic [CNT_W-1:0] lcLoadVal,
  input  logic             escLoadEn,
  input  logic [CNT_W-1:0] escLoadVal,
  input  loop_strobe_t     strobe,
  output logic             lcZero,
  output logic             escZero
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] lcQ;
  logic [CNT_W-1:0] escQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lcQ  <= '0;
      escQ <= '0;
    end else begin
      if (lcLoadEn)                  lcQ <= lcLoadVal;
      else if (strobe.decLc && !lcZero) lcQ <= lcQ - ONE;
      if (escLoadEn)                 escQ <= escLoadVal;
      else if (strobe.decEsc && !escZero) escQ <= escQ - ONE;
    end
  end

  assign lcZero  = (lcQ == '0);
  assign escZero = (escQ == '0);

  // R2: a trip decrement lowers the counter by exactly one
  assert_lc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decLc && !lcLoadEn) |=> lcQ == $past(lcQ) - ONE);

  // R4: the trip counter stays at zero without a load
  assert_lc_no_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!lcLoadEn && lcZero) |=> lcZero);

  // R4: the drain counter stays at zero without a load
  assert_esc_no_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!escLoadEn && escZero) |=> escZero);

endmodule

// File: rtl/modulo_loop_predfile.sv
module modulo_loop_predfile
  import modulo_loop_pkg::*;
#(
  parameter int PRED_N = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  loop_strobe_t      strobe,
  input  logic              initEn,
  input  logic [PRED_N-1:0] initVal,
  output logic [PRED_N-1:0] stageEn
);

  localparam int              PTR_W = (PRED_N > 1) ? $clog2(PRED_N) : 1;
  localparam logic [PTR_W:0]  WRAP  = (PTR_W+1)'(PRED_N);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(PRED_N - 1);

  logic [PRED_N-1:0] slotQ;
  logic [PTR_W-1:0]  ptrQ;
  logic [PTR_W-1:0]  ptrNext;
  logic [PTR_W-1:0]  slotIdx [PRED_N];

  assign ptrNext = (ptrQ == '0) ? LAST : ptrQ - PTR_W'(1);

  for (genvar i = 0; i < PRED_N; i++) begin : g_map
    localparam logic [PTR_W:0] OFF = (PTR_W+1)'(i);
    logic [PTR_W:0] rawSum;
    assign rawSum     = {1'b0, ptrQ} + OFF;
    assign slotIdx[i] = (rawSum >= WRAP) ? PTR_W'(rawSum - WRAP) : rawSum[PTR_W-1:0];
    assign stageEn[i] = slotQ[slotIdx[i]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQ <= '0;
      ptrQ  <= '0;
    end else if (initEn) begin
      for (int i = 0; i < PRED_N; i++) slotQ[slotIdx[i]] <= initVal[i];
    end else if (strobe.rotate) begin
      ptrQ           <= ptrNext;
      slotQ[ptrNext] <= strobe.newBit;
    end
  end

  // R12: initialization lands in logical stage order
  assert_init_order_R12: assert property (@(posedge clk) disable iff (!rstN)
    initEn |=> stageEn == $past(initVal));

  // R2: a rotation shifts the stage vector up by one
  assert_shift_up_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rotate && !initEn) |=> stageEn[PRED_N-1:1] == $past(stageEn[PRED_N-2:0]));

  // R3: the bit entering stage 0 is the one requested
  assert_new_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rotate && !initEn) |=> stageEn[0] == $past(strobe.newBit));

  // R4: no rotation and no init leaves the vector alone
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rotate && !initEn) |=> $stable(stageEn));

endmodule

// File: rtl/modulo_loop_ctl.sv
module modulo_loop_ctl
  import modulo_loop_pkg::*;
#(
  parameter int PRED_N = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic              loopCond,
  input  logic              inPred,
  input  logic              lcLoadEn,
  input  logic [CNT_W-1:0]  lcLoadVal,
  input  logic              escLoadEn,
  input  logic [CNT_W-1:0]  escLoadVal,
  input  logic              predInitEn,
  input  logic [PRED_N-1:0] predInitVal,
  output logic              brTaken,
  output logic [PRED_N-1:0] stageEn
);

  loop_strobe_t strobe;
  logic         lcZero;
  logic         escZero;
  logic         anyLoad;

  assign anyLoad = lcLoadEn | escLoadEn | predInitEn;

  modulo_loop_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opCode   (opCode),
    .loopCond (loopCond),
    .inPred   (inPred),
    .anyLoad  (anyLoad),
    .lcZero   (lcZero),
    .escZero  (escZero),
    .strobe   (strobe),
    .brTaken  (brTaken)
  );

  modulo_loop_counters #(.CNT_W(CNT_W)) u_counters (
    .clk        (clk),
    .rstN       (rstN),
    .lcLoadEn   (lcLoadEn),
    .lcLoadVal  (lcLoadVal),
    .escLoadEn  (escLoadEn),
    .escLoadVal (escLoadVal),
    .strobe     (strobe),
    .lcZero     (lcZero),
    .escZero    (escZero)
  );

  modulo_loop_predfile #(.PRED_N(PRED_N)) u_predfile (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .initEn  (predInitEn),
    .initVal (predInitVal),
    .stageEn (stageEn)
  );

endmodule

// File: tb/modulo_loop_ctl_tb_top.sv
module modulo_loop_ctl_tb_top;
  localparam int PN = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [2:0] opCode = 3'd0;
  logic loopCond = 1'b0, inPred = 1'b0;
  logic lcLoadEn = 1'b0, escLoadEn = 1'b0, predInitEn = 1'b0;
  logic [CW-1:0] lcLoadVal = '0, escLoadVal = '0;
  logic [PN-1:0] predInitVal = '0;
  logic brTaken;
  logic [PN-1:0] stageEn;

  always #5 clk = ~clk;

  modulo_loop_ctl #(.PRED_N(PN), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .loopCond(loopCond), .inPred(inPred),
    .lcLoadEn(lcLoadEn), .lcLoadVal(lcLoadVal),
    .escLoadEn(escLoadEn), .escLoadVal(escLoadVal),
    .predInitEn(predInitEn), .predInitVal(predInitVal),
    .brTaken(brTaken), .stageEn(stageEn)
  );

  int checks = 0;
  int errs = 0;
  bit finished = 1'b0;
  int mLc = 0, mEsc = 0;
  logic [PN-1:0] mEn = '0;

  task automatic check(string req, logic gotT, logic expT, logic [PN-1:0] gotE, logic [PN-1:0] expE);
    checks++;
    if (gotT !== expT || gotE !== expE) begin
      errs++;
      $display("FAIL %s: taken=%b en=%b, expected taken=%b en=%b", req, gotT, gotE, expT, expE);
    end
  endtask

  task automatic checkInt(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got %0d, expected %0d", req, got, exp);
    end
  endtask

  // one clock: drive at falling edge, model, compare at next falling edge
  task automatic step(string req, logic v, logic [2:0] op, logic c, logic ip,
                      logic ll, int lv, logic el, int ev, logic pi, logic [PN-1:0] pv);
    logic t;
    logic nb;
    bit cont;
    opValid = v; opCode = op; loopCond = c; inPred = ip;
    lcLoadEn = ll; lcLoadVal = CW'(lv); escLoadEn = el; escLoadVal = CW'(ev);
    predInitEn = pi; predInitVal = pv;
    t = 1'b0;
    if (ll || el || pi) begin
      if (ll) mLc = lv;
      if (el) mEsc = ev;
      if (pi) mEn = pv;
    end else if (v) begin
      case (op)
        3'd1, 3'd2: begin
          cont = (mLc > 0) || (mEsc > 0);
          t = (op == 3'd1) ? cont : (mLc == 0);
          if (mLc > 0) begin mLc--; mEn = {mEn[PN-2:0], 1'b1}; end
          else if (mEsc > 0) begin mEsc--; mEn = {mEn[PN-2:0], 1'b0}; end
        end
        3'd3, 3'd4: begin
          nb = c & ip;
          cont = nb || (mEsc > 0);
          t = (op == 3'd3) ? cont : !nb;
          if (nb) mEn = {mEn[PN-2:0], 1'b1};
          else if (mEsc > 0) begin mEsc--; mEn = {mEn[PN-2:0], 1'b0}; end
        end
        3'd5: mEn = {mEn[PN-2:0], 1'b1};
        default: ;
      endcase
    end
    @(negedge clk);
    check(req, brTaken, t, stageEn, mEn);
    opValid = 1'b0; lcLoadEn = 1'b0; escLoadEn = 1'b0; predInitEn = 1'b0;
  endtask

  task automatic doOp(string req, logic [2:0] op, logic c = 1'b0, logic ip = 1'b0);
    step(req, 1'b1, op, c, ip, 1'b0, 0, 1'b0, 0, 1'b0, '0);
  endtask

  task automatic doLoad(string req, int lv, int ev, logic [PN-1:0] pv);
    step(req, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, lv, 1'b1, ev, 1'b1, pv);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errs++;
      $display("FAIL R11: watchdog expired, got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  initial begin
    int takenCnt;
    int stage4Cnt;
    repeat (2) @(negedge clk);
    check("R1 reset", brTaken, 1'b0, stageEn, '0);
    rstN = 1'b1;
    step("R1 idle after reset", 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, '0);

    // R9: loads with a simultaneous loop-back op; op discarded
    step("R9", 1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 6, 1'b1, 4, 1'b1, 8'b0000_0001);

    // R2/R3/R4: 5-stage loop of 7 iterations
    takenCnt = 0; stage4Cnt = 0;
    for (int k = 0; k < 11; k++) begin
      if (stageEn[4]) stage4Cnt++;
      doOp(k < 6 ? "R2" : (k < 10 ? "R3" : "R4"), 3'd1);
      if (brTaken) takenCnt++;
    end
    checkInt("R3 taken count", takenCnt, 10);
    checkInt("R2 stage 4 passes", stage4Cnt, 7);
    doOp("R4 repeat at zero", 3'd1);
    step("R11 idle", 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, '0);

    // R5: counted quit
    doLoad("R9 load", 2, 1, 8'b0000_0001);
    for (int k = 0; k < 4; k++) doOp("R5", 3'd2);

    // R6: conditional loop-back, trip counter loaded but ignored
    doLoad("R9 load", 5, 2, 8'b0000_0000);
    doOp("R6", 3'd3, 1'b1, 1'b1);
    doOp("R6", 3'd3, 1'b1, 1'b1);
    doOp("R6", 3'd3, 1'b1, 1'b0);
    doOp("R6", 3'd3, 1'b0, 1'b1);
    doOp("R6", 3'd3, 1'b0, 1'b0);
    doOp("R6", 3'd3, 1'b0, 1'b0);

    // R7: conditional quit
    doLoad("R9 load", 0, 1, 8'b0000_0000);
    doOp("R7", 3'd4, 1'b1, 1'b1);
    doOp("R7", 3'd4, 1'b0, 1'b1);
    doOp("R7", 3'd4, 1'b0, 1'b0);

    // R8: rotate with counters at zero
    for (int k = 0; k < 3; k++) doOp("R8", 3'd5);

    // R10: unused op codes
    doLoad("R9 load", 3, 3, 8'b0101_0101);
    doOp("R10 op0", 3'd0);
    doOp("R10 op6", 3'd6);
    doOp("R10 op7", 3'd7);
    step("R11 no strobe", 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, '0);

    // R12: init after the pointer has moved
    doOp("R12 pre-rotate", 3'd5);
    doOp("R12 pre-rotate", 3'd5);
    step("R12 init", 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b1, 8'b1011_0010);
    doOp("R12 rotate after init", 3'd1);
    doOp("R12 rotate after init", 3'd5);
    step("R12 init", 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b1, 8'b0000_0001);
    doOp("R12 rotate", 3'd1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule